// File: doc/BRIEF.md
# Effective Operand Address Generator

This block works out the 16-bit address of a memory operand for a two-operand instruction. It receives the instruction's extension flag, index-register selector, indirect flag and byte flag, the instruction's own address, and an addressing class: plain, pre-decrement or post-increment. It fetches the extension word and any pointer words through a read port with a one-cycle latency. It reads the index register from an eight-entry register file in which entry 0 is the program counter. It writes the stepped index back once, in the completion cycle.

The sequence is always the same. The extension word forms the base (zero when absent). The index is then pre-decremented if asked and added when a register is selected. Pointer words are followed next. The index is post-incremented last. A pointer whose bit 0 is set leads to a further pointer in word mode. Byte mode follows one pointer only. A chain that is too deep ends in a trap. A request that selects neither an extension word nor an index register also traps.

The controller is one state machine with states IDLE, EXT_REQ, EXT_WAIT, FORM, IND_REQ, IND_WAIT and DONE.
- IDLE goes to DONE on a trap request, to EXT_REQ when an extension word is used, and to FORM otherwise.
- EXT_REQ goes to EXT_WAIT, and EXT_WAIT goes to FORM.
- FORM goes to IND_REQ when indirection is asked for, and to DONE otherwise.
- IND_REQ goes to IND_WAIT.
- IND_WAIT goes back to IND_REQ to follow another pointer, to DONE when the chain ends, and to DONE with a trap when the depth limit is reached.
- DONE returns to IDLE.

Top module: `opaddr_gen`

## Requirements
- R1: The formed address is the base plus the index. The base is the word read at (instruction address + 2) when `ext_en`=1, and zero otherwise. The index is the selected register's value when `idx_sel`≠0, and nothing is added when `idx_sel`=0. All sums wrap at 16 bits.
- R2: `addr_mode` encodings:
  - 2'b00 is plain: the register is left unchanged.
  - 2'b01 is pre-decrement: the stepped value is used as the index and is written back.
  - 2'b10 is post-increment: the address is formed from the old value, and old value plus the step is written back.
  - 2'b11 behaves as plain.
  The step is 1 when `byte_op`=1 and 2 when `byte_op`=0.
- R3: With `idx_sel`=0 and a stepping mode, register 0 (the program counter) is stepped and written back, and no index is added to the address.
- R4: `ext_en`=0 together with `idx_sel`=0 raises `done` and `trap` one cycle after `start`. In that case no memory read is issued and no register is written.
- R5: With `ind_en`=1 the formed address is replaced by the word read from it. Every memory read address has bit 0 cleared.
- R6: In word mode, a fetched pointer with bit 0 = 1 is itself followed as a pointer. The chain ends at the first pointer with bit 0 = 0, which becomes the address.
- R7: A word-mode chain may fetch at most 16 pointers. If the 16th fetched pointer still has bit 0 = 1, the operation ends with `trap` and no write-back. A chain of exactly 16 fetches that ends on an even pointer completes normally.
- R8: In byte mode, `lane_right` equals address bit 0: 1 selects bits 7..0 and 0 selects bits 15..8. In word mode, `ea_addr` bit 0 and `lane_right` are 0.
- R9: `loop_done` is 1 in the completion cycle when a stepping mode wrote back a value of zero. It is 0 in every other case.
- R10: `done` is a one-cycle pulse. Its latency after `start` is 2 cycles without an extension word and 4 cycles with one, plus 2 for each pointer fetched. The register write-back happens only in that cycle.
- R11: In byte mode only one pointer is followed, and its bit 0 is kept as the byte lane even when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation (sampled in IDLE) |
| ext_en | input | 1 | An extension word follows the instruction |
| idx_sel | input | 3 | Index register selector; 0 means no indexing |
| ind_en | input | 1 | Indirect addressing requested |
| byte_op | input | 1 | Byte operand (1) or word operand (0) |
| addr_mode | input | 2 | 00 plain, 01 pre-decrement, 10 post-increment, 11 plain |
| instr_addr | input | 16 | Address of the current instruction |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address (even) |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| rf_rd_sel | output | 3 | Register file read selector |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_sel | output | 3 | Register file write selector |
| rf_wr_data | output | 16 | Register file write data |
| done | output | 1 | Completion pulse |
| trap | output | 1 | Unimplemented-instruction trap, valid with done |
| ea_addr | output | 16 | Effective operand address, valid with done |
| lane_right | output | 1 | Byte lane select, valid with done |
| idx_new | output | 16 | Stepped index value, valid with done |
| loop_done | output | 1 | Stepped index reached zero, valid with done |

## Verification
The hardest situation to reach is the depth-limit trap. It needs sixteen consecutive pointer words, each with bit 0 set and each naming the next. The bench builds this chain in its memory model and starts an indirect word-mode request at its head. It then changes only the last link to an even value, which checks the boundary where exactly sixteen fetches must complete without a trap. The reference model follows the same chain behaviourally and predicts the cycle of `done` from the number of fetches.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT_REQ,
        ST_EXT_WAIT,
        ST_FORM,
        ST_IND_REQ,
        ST_IND_WAIT,
        ST_DONE
    } oag_state_t;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'b00,
        AM_PREDEC  = 2'b01,
        AM_POSTINC = 2'b10,
        AM_RSVD    = 2'b11
    } oag_mode_t;

endpackage

// File: rtl/opaddr_stepper.sv
module opaddr_stepper
    import opaddr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx_in,
    input  logic          byte_op,
    input  oag_mode_t     mode,
    output logic [AW-1:0] idx_used,
    output logic [AW-1:0] idx_after,
    output logic          step_en
);
    logic [AW-1:0] step;

    always_comb begin
        step = byte_op ? AW'(1) : AW'(2);
        idx_used  = idx_in;
        idx_after = idx_in;
        step_en   = 1'b0;
        unique case (mode)
            AM_PREDEC: begin
                idx_used  = idx_in - step;
                idx_after = idx_in - step;
                step_en   = 1'b1;
            end
            AM_POSTINC: begin
                idx_after = idx_in + step;
                step_en   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opaddr_depth.sv
module opaddr_depth #(
    parameter int MAX_LEVELS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(MAX_LEVELS + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && count != CW'(MAX_LEVELS))
            count <= count + 1'b1;
    end

    assign at_last = (count == CW'(MAX_LEVELS - 1));

    // R7: the pointer count never passes the limit
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_LEVELS));

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int AW         = 16,
    parameter int NREG       = 8,
    parameter int MAX_LEVELS = 16,
    localparam int RSEL      = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            ext_en,
    input  logic [RSEL-1:0] idx_sel,
    input  logic            ind_en,
    input  logic            byte_op,
    input  logic [1:0]      addr_mode,
    input  logic [AW-1:0]   instr_addr,
    output logic            mem_rd_req,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic [AW-1:0]   mem_rd_data,
    output logic [RSEL-1:0] rf_rd_sel,
    input  logic [AW-1:0]   rf_rd_data,
    output logic            rf_wr_en,
    output logic [RSEL-1:0] rf_wr_sel,
    output logic [AW-1:0]   rf_wr_data,
    output logic            done,
    output logic            trap,
    output logic [AW-1:0]   ea_addr,
    output logic            lane_right,
    output logic [AW-1:0]   idx_new,
    output logic            loop_done
);
    localparam logic [AW-1:0] EXT_OFS = AW'(2);
    localparam logic [AW-1:0] EVEN_MASK = ~AW'(1);

    oag_state_t state, state_nx;

    logic            ext_q, ind_q, byte_q, trap_q;
    logic [RSEL-1:0] xr_q;
    oag_mode_t       mode_q;
    logic [AW-1:0]   pc_q, idx_q, base_q, addr_q;

    logic [AW-1:0] idx_used, idx_after;
    logic          step_en;
    logic          at_last;
    logic          no_addr;
    logic          chain_more;

    assign no_addr    = !ext_en && (idx_sel == '0);
    assign chain_more = !byte_q && mem_rd_data[0];

    opaddr_stepper #(.AW(AW)) u_step (
        .idx_in   (idx_q),
        .byte_op  (byte_q),
        .mode     (mode_q),
        .idx_used (idx_used),
        .idx_after(idx_after),
        .step_en  (step_en)
    );

    opaddr_depth #(.MAX_LEVELS(MAX_LEVELS)) u_depth (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == ST_IDLE && start),
        .inc    (state == ST_IND_WAIT),
        .at_last(at_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (no_addr)     state_nx = ST_DONE;
                    else if (ext_en) state_nx = ST_EXT_REQ;
                    else             state_nx = ST_FORM;
                end
            end
            ST_EXT_REQ:  state_nx = ST_EXT_WAIT;
            ST_EXT_WAIT: state_nx = ST_FORM;
            ST_FORM:     state_nx = ind_q ? ST_IND_REQ : ST_DONE;
            ST_IND_REQ:  state_nx = ST_IND_WAIT;
            ST_IND_WAIT: begin
                if (chain_more && !at_last) state_nx = ST_IND_REQ;
                else                        state_nx = ST_DONE;
            end
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            ind_q  <= 1'b0;
            byte_q <= 1'b0;
            trap_q <= 1'b0;
            xr_q   <= '0;
            mode_q <= AM_PLAIN;
            pc_q   <= '0;
            idx_q  <= '0;
            base_q <= '0;
            addr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ext_q  <= ext_en;
                        ind_q  <= ind_en;
                        byte_q <= byte_op;
                        trap_q <= no_addr;
                        xr_q   <= idx_sel;
                        mode_q <= oag_mode_t'(addr_mode);
                        pc_q   <= instr_addr;
                        idx_q  <= rf_rd_data;
                        base_q <= '0;
                    end
                end
                ST_EXT_WAIT: base_q <= mem_rd_data;
                ST_FORM: begin
                    if (xr_q != '0) addr_q <= base_q + idx_used;
                    else            addr_q <= base_q;
                end
                ST_IND_WAIT: begin
                    addr_q <= mem_rd_data;
                    if (chain_more && at_last) trap_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_req  = 1'b0;
        mem_rd_addr = '0;
        done        = 1'b0;
        unique case (state)
            ST_EXT_REQ: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = (pc_q + EXT_OFS) & EVEN_MASK;
            end
            ST_IND_REQ: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = addr_q & EVEN_MASK;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        rf_rd_sel  = (state == ST_IDLE) ? idx_sel : xr_q;
        trap       = done && trap_q;
        rf_wr_en   = done && !trap_q && step_en;
        rf_wr_sel  = xr_q;
        rf_wr_data = idx_after;
        idx_new    = idx_after;
        loop_done  = rf_wr_en && (idx_after == '0);
        ea_addr    = byte_q ? addr_q : (addr_q & EVEN_MASK);
        lane_right = byte_q && addr_q[0];
    end

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: every memory fetch is word aligned
    assert_fetch_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !mem_rd_addr[0]);

    // R4: a trapped operation writes no register
    assert_trap_nowb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap) |-> !rf_wr_en);

    // R4: a request with no address source traps in the next cycle
    assert_noaddr_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !ext_en && idx_sel == '0) |=> (done && trap));

    // R8: word results are even and select no byte lane
    assert_word_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !trap && !byte_q) |-> (!ea_addr[0] && !lane_right));

    // R9: loop-complete only with a zero written back
    assert_loop_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> (rf_wr_en && rf_wr_data == '0));

    // R10: write-back only in the completion cycle
    assert_wb_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done);

endmodule

// File: tb/opaddr_gen_bench.sv
`timescale 1ns/1ps
module opaddr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ext_en = 1'b0;
    logic [2:0]  idx_sel = '0;
    logic        ind_en = 1'b0;
    logic        byte_op = 1'b0;
    logic [1:0]  addr_mode = '0;
    logic [15:0] instr_addr = 16'h0040;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic [2:0]  rf_rd_sel;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [15:0] rf_wr_data;
    logic        done, trap, lane_right, loop_done;
    logic [15:0] ea_addr, idx_new;

    logic [15:0] mem [0:255];
    logic [15:0] rf  [0:7];

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    opaddr_gen u_opaddr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_en(ext_en),
        .idx_sel(idx_sel), .ind_en(ind_en), .byte_op(byte_op),
        .addr_mode(addr_mode), .instr_addr(instr_addr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .rf_rd_sel(rf_rd_sel),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel),
        .rf_wr_data(rf_wr_data), .done(done), .trap(trap), .ea_addr(ea_addr),
        .lane_right(lane_right), .idx_new(idx_new), .loop_done(loop_done)
    );

    assign rf_rd_data = rf[rf_rd_sel];

    always @(posedge clk) begin
        if (mem_rd_req) mem_rd_data <= mem[mem_rd_addr[8:1]];
        if (rf_wr_en)   rf[rf_wr_sel] <= rf_wr_data;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(input logic [15:0] a);
        return mem[a[8:1]];
    endfunction

    // behavioural reference plus per-cycle comparison
    task automatic run_op(input string req, input logic e, input logic [2:0] xr,
                          input logic ind, input logic b, input logic [1:0] md);
        logic [15:0] step, x, xp, xn, a, p;
        int n, lat;
        logic etrap, wb, lp;
        step = b ? 16'd1 : 16'd2;
        x = rf[xr];
        n = 0;
        etrap = (!e && xr == 0);
        xp = (md == 2'b01) ? x - step : x;
        xn = (md == 2'b01) ? x - step : (md == 2'b10) ? x + step : x;
        a = e ? rd(instr_addr + 16'd2) : 16'd0;
        if (xr != 0) a = a + xp;
        if (!etrap && ind) begin
            for (int k = 0; k < 64; k++) begin
                p = rd(a);
                n++;
                a = p;
                if (b || !p[0]) break;
                if (n == 16) begin etrap = 1'b1; break; end
            end
        end
        if (!e && xr == 0) lat = 1;
        else               lat = (e ? 4 : 2) + 2 * n;
        wb = !etrap && (md == 2'b01 || md == 2'b10);
        lp = wb && (xn == 16'd0);
        if (!b) a[0] = 1'b0;

        @(negedge clk);
        ext_en = e; idx_sel = xr; ind_en = ind; byte_op = b; addr_mode = md;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 1; j <= lat; j++) begin
            chk(req, "done timing", 32'(done), 32'(j == lat));
            chk(req, "write strobe", 32'(rf_wr_en), 32'(j == lat && wb));
            if (!e && xr == 0) chk("R4", "no read", 32'(mem_rd_req), 32'd0);
            if (j == lat) begin
                chk(req, "trap", 32'(trap), 32'(etrap));
                chk("R9", "loop_done", 32'(loop_done), 32'(lp));
                if (!etrap) begin
                    chk(req, "ea_addr", 32'(ea_addr), 32'(a));
                    chk("R8", "lane", 32'(lane_right), 32'(b && a[0]));
                    chk(req, "idx_new", 32'(idx_new), 32'(xn));
                end
            end
            if (j < lat) @(negedge clk);
        end
        @(negedge clk);
        chk(req, "register after", 32'(rf[xr]), 32'(wb ? xn : x));
        chk("R10", "done dropped", 32'(done), 32'd0);
    endtask

    initial begin
        #200000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        for (int i = 0; i < 8; i++) rf[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R10", "reset done", 32'(done), 32'd0);
        chk("R10", "reset read", 32'(mem_rd_req), 32'd0);
        chk("R10", "reset write", 32'(rf_wr_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: extension word only
        mem[8'h21] = 16'h1234;
        run_op("R1", 1'b1, 3'd0, 1'b0, 1'b0, 2'b00);
        // R1 with R8: extension plus odd index in word mode, bit 0 cleared
        mem[8'h21] = 16'h0100; rf[3] = 16'h0011;
        run_op("R1", 1'b1, 3'd3, 1'b0, 1'b0, 2'b00);
        // R2 post-increment byte, odd address selects the right lane
        rf[3] = 16'h0011;
        run_op("R2", 1'b0, 3'd3, 1'b0, 1'b1, 2'b10);
        // R2 pre-decrement word with extension
        mem[8'h21] = 16'h0200; rf[5] = 16'h0008;
        run_op("R2", 1'b1, 3'd5, 1'b0, 1'b0, 2'b01);
        // R2 reserved encoding acts as plain
        rf[7] = 16'h0044;
        run_op("R2", 1'b1, 3'd7, 1'b0, 1'b0, 2'b11);
        // R4 no address source
        run_op("R4", 1'b0, 3'd0, 1'b0, 1'b0, 2'b10);
        // R3 program counter stepped when no index is selected
        mem[8'h21] = 16'h0300; rf[0] = 16'h0100;
        run_op("R3", 1'b1, 3'd0, 1'b0, 1'b0, 2'b10);
        // R5 single-level indirection
        rf[2] = 16'h0060; mem[8'h30] = 16'h0150;
        run_op("R5", 1'b0, 3'd2, 1'b1, 1'b0, 2'b00);
        // R6 three-level chain starting from an odd index
        rf[2] = 16'h0061; mem[8'h30] = 16'h0081; mem[8'h40] = 16'h00A1;
        mem[8'h50] = 16'h00C0;
        run_op("R6", 1'b0, 3'd2, 1'b1, 1'b0, 2'b00);
        // R7 sixteen odd pointers end in a trap
        for (int k = 0; k < 16; k++)
            mem[8'h80 + k] = (16'h0100 + 16'(2 * (k + 1))) | 16'h0001;
        rf[4] = 16'h0100;
        run_op("R7", 1'b0, 3'd4, 1'b1, 1'b0, 2'b10);
        // R7 exactly sixteen fetches ending even complete normally
        mem[8'h8F] = 16'h0AB0; rf[4] = 16'h0100;
        run_op("R7", 1'b0, 3'd4, 1'b1, 1'b0, 2'b10);
        // R11 byte mode follows one pointer and keeps its odd bit
        rf[6] = 16'h0070; mem[8'h38] = 16'h0033;
        run_op("R11", 1'b0, 3'd6, 1'b1, 1'b1, 2'b00);
        // R9 pre-decrement reaching zero
        rf[1] = 16'h0002;
        run_op("R9", 1'b0, 3'd1, 1'b0, 1'b0, 2'b01);
        // R9 post-increment wrapping to zero
        rf[1] = 16'hFFFE;
        run_op("R9", 1'b0, 3'd1, 1'b0, 1'b0, 2'b10);
        // R10 latency with extension and one pointer
        mem[8'h21] = 16'h0010; rf[3] = 16'h0002; mem[8'h09] = 16'h0042;
        run_op("R10", 1'b1, 3'd3, 1'b1, 1'b0, 2'b01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule